// File: doc/BRIEF.md
# Registered-Output Shift-Register Stream Queue

This block is a first-in, first-out buffer placed between a producer and a consumer that talk over valid/backpressure streams. Each stream word carries a data field and one end-of-stream bit, and the two travel together through the queue. A word moves across either interface only at a rising clock edge where the sender drives valid high and the receiver holds backpressure low.

Storage is split in two parts. The head of the queue is an output data register that drives the consumer side. The remaining entries sit in a shift register: every accepted word enters at slot 0 and pushes the older words one slot up, and the oldest one is picked out by an address. A three-state occupancy controller (empty, one word, more than one word) steers each word. A word that arrives at an empty queue goes straight into the output register. When the head is taken, the output register refills from the addressed slot. Output valid and input backpressure are both flip-flops, loaded from next-state values, so every output of the block comes from a register.

Top module: `srq_fifo`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_vld` and `in_bp` are both 0.
- R2: Words leave in the order they were accepted, with no loss and no duplication, and each word keeps its own `in_eos` bit.
- R3: `in_bp` is 1 exactly when the queue holds DEPTH words. It changes one cycle after the edge that changes the occupancy.
- R4: `out_vld` is 1 exactly when the queue holds at least one word. A word accepted into an empty queue is presented on the consumer side in the next cycle.
- R5: A word offered while `in_bp` is 1 is not accepted and has no effect on the queue contents or flags.
- R6: An accept and a removal in the same edge leave the occupancy unchanged, so `in_bp` and `out_vld` keep their values.
- R7: While `out_vld` is 1 and `out_bp` is 1, `out_data` and `out_eos` stay unchanged and `out_vld` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Producer offers a word |
| in_data | input | WIDTH | Producer data |
| in_eos | input | 1 | End-of-stream bit of the offered word |
| in_bp | output | 1 | Backpressure to the producer, registered (queue full) |
| out_vld | output | 1 | Head word available, registered |
| out_data | output | WIDTH | Head word data, registered |
| out_eos | output | 1 | Head word end-of-stream bit, registered |
| out_bp | input | 1 | Backpressure from the consumer |

## Verification
The checker rebuilds the occupancy from the port handshakes alone. It therefore relies on the producer obeying the transfer rule: a word counts as taken only in a cycle where `in_bp` was low. It also assumes that `out_bp` and the inputs are settled before each rising edge. The bench drives all inputs at the falling edge. Its random phases pick `in_vld` and `out_bp` independently each cycle, so the queue sweeps between empty and full. Directed phases keep the producer pushing against a full queue to show that the extra words are dropped. Other directed phases hold the consumer stalled with a valid head, and run a mixed accept-and-remove stretch just below capacity.

// File: rtl/srq_pkg.sv
package srq_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ONE   = 2'd1,
        OCC_MORE  = 2'd2
    } occ_state_e;
endpackage

// File: rtl/srq_store.sv
module srq_store #(
    parameter int unsigned ENTRIES = 7,
    parameter int unsigned WORD_W  = 9,
    parameter int unsigned AW      = 3
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] slot_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (shift_en) slot_q[0] <= wr_word;
    end

    for (genvar g = 1; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (shift_en) slot_q[g] <= slot_q[g-1];
        end
    end

    assign rd_word = slot_q[rd_addr];
endmodule

// File: rtl/srq_ctrl.sv
module srq_ctrl
    import srq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          out_bp,
    output logic          full,
    output logic          head_vld,
    output logic          shift_en,
    output logic          load_en,
    output logic          load_from_in,
    output logic [AW-1:0] rd_addr
);
    localparam logic [AW-1:0] ADDR_TOP  = AW'(DEPTH - 2);
    localparam logic [AW-1:0] ADDR_NEAR = AW'(DEPTH - 3);

    typedef struct packed {
        occ_state_e    st;
        logic [AW-1:0] addr;
        logic          vld;
        logic          full;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  push, pop;

    always_comb begin
        push         = in_vld & ~ctl_q.full;
        pop          = ctl_q.vld & ~out_bp;
        ctl_d        = ctl_q;
        shift_en     = 1'b0;
        load_en      = 1'b0;
        load_from_in = 1'b0;
        ctl_d.full   = 1'b0;
        case (ctl_q.st)
            OCC_EMPTY: begin
                if (push) begin
                    load_en      = 1'b1;
                    load_from_in = 1'b1;
                    ctl_d.st     = OCC_ONE;
                end
            end
            OCC_ONE: begin
                if (push && pop) begin
                    load_en      = 1'b1;
                    load_from_in = 1'b1;
                end else if (push) begin
                    shift_en   = 1'b1;
                    ctl_d.addr = '0;
                    ctl_d.st   = OCC_MORE;
                end else if (pop) begin
                    ctl_d.st = OCC_EMPTY;
                end
            end
            OCC_MORE: begin
                if (push && pop) begin
                    shift_en   = 1'b1;
                    load_en    = 1'b1;
                    ctl_d.full = (ctl_q.addr == ADDR_TOP);
                end else if (push) begin
                    shift_en   = 1'b1;
                    ctl_d.addr = ctl_q.addr + 1'b1;
                    ctl_d.full = (ctl_q.addr == ADDR_NEAR);
                end else if (pop) begin
                    load_en = 1'b1;
                    if (ctl_q.addr == '0) ctl_d.st = OCC_ONE;
                    else                  ctl_d.addr = ctl_q.addr - 1'b1;
                end else begin
                    ctl_d.full = (ctl_q.addr == ADDR_TOP);
                end
            end
            default: ctl_d.st = OCC_EMPTY;
        endcase
        ctl_d.vld = (ctl_d.st != OCC_EMPTY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: OCC_EMPTY, addr: '0, vld: 1'b0, full: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign full     = ctl_q.full;
    assign head_vld = ctl_q.vld;
    assign rd_addr  = ctl_q.addr;
endmodule

// File: rtl/srq_outreg.sv
module srq_outreg #(
    parameter int unsigned WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              load_from_in,
    input  logic [WORD_W-1:0] in_word,
    input  logic [WORD_W-1:0] sr_word,
    output logic [WORD_W-1:0] head_word
);
    logic [WORD_W-1:0] head_d, head_q;

    always_comb begin
        head_d = head_q;
        if (load_en) head_d = load_from_in ? in_word : sr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) head_q <= '0;
        else        head_q <= head_d;
    end

    assign head_word = head_q;
endmodule

// File: rtl/srq_fifo.sv
module srq_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_eos,
    output logic             in_bp,
    output logic             out_vld,
    output logic [WIDTH-1:0] out_data,
    output logic             out_eos,
    input  logic             out_bp
);
    localparam int unsigned SR_N   = DEPTH - 1;
    localparam int unsigned WORD_W = WIDTH + 1;
    localparam int unsigned AW     = (SR_N > 1) ? $clog2(SR_N) : 1;

    logic              shift_en, load_en, load_from_in;
    logic [AW-1:0]     rd_addr;
    logic [WORD_W-1:0] in_word, sr_word, head_word;

    assign in_word = {in_eos, in_data};

    srq_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .out_bp(out_bp),
        .full(in_bp), .head_vld(out_vld), .shift_en(shift_en),
        .load_en(load_en), .load_from_in(load_from_in), .rd_addr(rd_addr)
    );

    srq_store #(.ENTRIES(SR_N), .WORD_W(WORD_W), .AW(AW)) u_store (
        .clk(clk), .shift_en(shift_en), .wr_word(in_word),
        .rd_addr(rd_addr), .rd_word(sr_word)
    );

    srq_outreg #(.WORD_W(WORD_W)) u_head (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_from_in(load_from_in),
        .in_word(in_word), .sr_word(sr_word), .head_word(head_word)
    );

    assign {out_eos, out_data} = head_word;
endmodule

// File: rtl/srq_fifo_chk.sv
module srq_fifo_chk #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic             in_bp,
    input logic             out_vld,
    input logic [WIDTH-1:0] out_data,
    input logic             out_eos,
    input logic             out_bp
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    logic [CW-1:0] occ_q;
    logic          acc, rem;

    assign acc = in_vld & ~in_bp;
    assign rem = out_vld & ~out_bp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_q + CW'(acc) - CW'(rem);
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (!out_vld && !in_bp));
    a_r3_bp_full: assert property (@(posedge clk) disable iff (!rst_n)
        in_bp == (occ_q == CW'(DEPTH)));
    a_r4_vld_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == (occ_q != '0));
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CW'(DEPTH));
    a_r6_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rem) |=> ($stable(in_bp) && out_vld));
    a_r7_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_bp) |=> (out_vld && $stable(out_data) && $stable(out_eos)));
endmodule

bind srq_fifo srq_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_bp(in_bp), .out_vld(out_vld),
    .out_data(out_data), .out_eos(out_eos), .out_bp(out_bp)
);

// File: tb/srq_fifo_bench.sv
`timescale 1ns/1ps
module srq_fifo_bench;
    localparam int WIDTH = 8;
    localparam int DEPTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_vld = 1'b0;
    logic [WIDTH-1:0] in_data = '0;
    logic             in_eos = 1'b0;
    logic             in_bp;
    logic             out_vld;
    logic [WIDTH-1:0] out_data;
    logic             out_eos;
    logic             out_bp = 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string tag = "R2";

    logic [WIDTH:0] mdl[$];
    bit             hold_prev = 0;
    logic [WIDTH:0] word_prev = '0;

    always #2.5 clk = ~clk;

    srq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_srq_fifo (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .in_eos(in_eos),
        .in_bp(in_bp), .out_vld(out_vld), .out_data(out_data), .out_eos(out_eos),
        .out_bp(out_bp)
    );

    function automatic bit exp_full(int n);
        return n == DEPTH;
    endfunction

    function automatic bit exp_vld(int n);
        return n != 0;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: compare at falling edge, drive, then update model after the rising edge
    task automatic step(bit v, logic [WIDTH-1:0] d, bit e, bit obp);
        bit push, pop;
        @(negedge clk);
        chk(in_bp == exp_full(mdl.size()), "R3 in_bp", int'(in_bp), int'(exp_full(mdl.size())));
        chk(out_vld == exp_vld(mdl.size()), "R4 out_vld", int'(out_vld), int'(exp_vld(mdl.size())));
        if (out_vld && mdl.size() != 0)
            chk({out_eos, out_data} == mdl[0], tag, int'({out_eos, out_data}), int'(mdl[0]));
        if (hold_prev)
            chk(out_vld && {out_eos, out_data} == word_prev, "R7 hold",
                int'({out_eos, out_data}), int'(word_prev));
        in_vld  = v;
        in_data = d;
        in_eos  = e;
        out_bp  = obp;
        push = v && !in_bp;
        pop  = out_vld && !obp;
        hold_prev = out_vld && obp;
        word_prev = {out_eos, out_data};
        @(posedge clk);
        if (pop)  void'(mdl.pop_front());
        if (push) mdl.push_back({e, d});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!out_vld, "R1 out_vld in reset", int'(out_vld), 0);
        chk(!in_bp, "R1 in_bp in reset", int'(in_bp), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_vld && !in_bp, "R1 after release", int'({out_vld, in_bp}), 0);

        // R4: single word into empty queue shows next cycle
        tag = "R4 first word";
        step(1, 8'hA5, 1, 1);
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        // R5: fill with consumer stalled, keep pushing against full queue
        tag = "R5 data after overfill";
        for (int i = 0; i < DEPTH + 6; i++) step(1, 8'(8'h10 + i), i[0], 1);
        chk(in_bp == 1'b1, "R3 full flag", int'(in_bp), 1);
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0);
        chk(!out_vld && mdl.size() == 0, "R5 drained count", int'(out_vld), 0);

        // R6: hover just below full with simultaneous push and pop
        tag = "R6 data";
        for (int i = 0; i < DEPTH - 1; i++) step(1, 8'(8'h40 + i), 0, 1);
        for (int i = 0; i < 10; i++) begin
            step(1, 8'(8'h60 + i), i[1], 0);
            chk(!in_bp && out_vld, "R6 flags kept", int'({in_bp, out_vld}), 1);
        end
        // full with simultaneous pop attempt: push blocked, pop releases bp
        step(1, 8'h7E, 0, 1);
        step(1, 8'h7F, 1, 0);
        step(0, 0, 0, 1);
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0);

        // R2 and R7: random traffic at several densities
        tag = "R2 order";
        for (int ph = 0; ph < 4; ph++) begin
            for (int i = 0; i < 800; i++) begin
                int pv, pb;
                pv = (ph == 0) ? 30 : (ph == 1) ? 80 : (ph == 2) ? 50 : 95;
                pb = (ph == 0) ? 70 : (ph == 1) ? 20 : (ph == 2) ? 50 : 60;
                step(($urandom % 100) < pv, 8'($urandom), 1'($urandom),
                     ($urandom % 100) < pb);
            end
        end
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0);
        @(negedge clk);
        chk(!out_vld && !in_bp && mdl.size() == 0, "R2 final empty",
            int'({out_vld, in_bp}), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule